// File: doc/BRIEF.md
# Shadowed Configuration Register

This block holds one configuration value that is guarded against fault injection. A value only reaches the hardware-facing output after the same data has been presented twice in a row. The first write goes into a staging store. The second write is compared with that store, and only a match updates the committed value. Besides the committed value, the block keeps a shadow copy of it. Both the staging store and the shadow copy hold the bitwise inverse of the data. The block compares the shadow copy with the committed value in every cycle, so a single flipped or glitched bit anywhere in that pair shows up on an error output.

The access type is fixed at build time by a parameter:
- **Plain replace**: the committed value becomes the written data.
- **Set-on-one**: the written data is ORed into the committed value.
- **Clear-on-zero**: the written data is ANDed into the committed value.
- **Hardware-owned**: software writes are ignored. Updates arrive on a dedicated hardware update port and follow the same two-step confirm rule.

A software read abandons a half-done update, except in the hardware-owned mode. A mismatching confirm write pulses an update error output. This output is informational only: the block has no bus response to alter.

Top module: `shadow_cfg_reg`

## Requirements
- R1: After a synchronous reset, `q` equals `RESVAL`, both error outputs are low, and the next write is treated as a first write.
- R2: A first write on the active update port leaves `q` unchanged and moves the block into the confirm phase.
- R3: A confirm write whose data equals the first write's data updates `q` at that clock edge and returns the block to the first phase. The new value depends on the access type: plain replace and hardware-owned give the data itself; set-on-one gives `q | data`; clear-on-zero gives `q & data`. The staging store holds the inverse of the first write's data.
- R4: A confirm write whose data differs from the staged data leaves `q` unchanged and returns the block to the first phase. It also raises `err_update` for exactly the one cycle after that edge.
- R5: In the set-on-one and clear-on-zero modes, the confirm comparison uses the raw data of both writes, before the set or clear rule is applied.
- R6: In the software-written modes, a read (`sw_re`) in a cycle with no write returns the block to the first phase. A write in the same cycle as a read takes priority over the read.
- R7: In the hardware-owned mode (`ACCESS` = `ACC_RO`, code 1), `sw_we` has no effect. Updates come from `hw_upd`/`hw_data` using the same two-write protocol, and `sw_re` does not reset the phase.
- R8: `err_storage` is high in the cycle after any cycle in which the shadow copy is not the inverse of the committed value. It stays high for as long as that disagreement lasts, and it falls the cycle after a commit restores agreement.
- R9: In the software-written modes (`ACC_RW` = 0, `ACC_W1S` = 2, `ACC_W0C` = 3), `hw_upd` and `hw_data` have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| sw_we | input | 1 | Software write strobe |
| sw_wdata | input | DATA_W | Software write data |
| sw_re | input | 1 | Software read strobe; abandons a pending update |
| hw_upd | input | 1 | Hardware update strobe (hardware-owned mode only) |
| hw_data | input | DATA_W | Hardware update data (hardware-owned mode only) |
| q | output | DATA_W | Committed value seen by hardware and by software reads |
| err_update | output | 1 | One-cycle pulse after a mismatching confirm write |
| err_storage | output | 1 | Shadow copy and committed value disagree |

## Verification
If the phase tracker is left in the wrong state, it shows up on the very next write. A genuine first write then either changes `q` too early, or raises `err_update` one cycle later where none was due. A staging store that holds the wrong value turns the following matching confirm write into a false `err_update`, and `q` then fails to move. A corrupted shadow or committed bit raises `err_storage` one cycle after the fault. That output stays high until a correct update sequence rewrites both copies. The sweep covers every pair of 4-bit first and confirm values in all four modes, so every comparison and set/clear outcome is seen at the ports.

// File: rtl/shadow_cfg_pkg.sv
package shadow_cfg_pkg;

  // Access behaviour of the committed value; codes are relied on by users.
  typedef enum logic [1:0] {
    ACC_RW  = 2'd0,  // replace
    ACC_RO  = 2'd1,  // hardware-owned, software writes ignored
    ACC_W1S = 2'd2,  // ones in data set bits
    ACC_W0C = 2'd3   // zeros in data clear bits
  } access_e;

endpackage

// File: rtl/shadow_cfg_phase.sv
module shadow_cfg_phase #(
  parameter bit RD_CLEARS = 1'b1
) (
  input  logic clk,
  input  logic rst,
  input  logic wr_ev,
  input  logic rd_ev,
  output logic second
);

  logic second_r;

  always_ff @(posedge clk) begin
    if (rst) begin
      second_r <= 1'b0;
    end else if (wr_ev) begin
      second_r <= ~second_r;
    end else if (rd_ev && RD_CLEARS) begin
      second_r <= 1'b0;
    end
  end

  assign second = second_r;

  AST_READ_PHASE: assert property (@(posedge clk) disable iff (rst)
    (rd_ev && !wr_ev && RD_CLEARS) |=> !second) else $error("read did not reset phase"); // R6

endmodule

// File: rtl/shadow_cfg_stage.sv
module shadow_cfg_stage #(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] RESVAL = '0
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [DATA_W-1:0] din,
  output logic              match
);

  logic [DATA_W-1:0] staged_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      staged_n <= ~RESVAL;
    end else if (load) begin
      staged_n <= ~din;
    end
  end

  // Raw data of the confirm write against the inverted staged copy.
  assign match = (din == ~staged_n);

  AST_STAGE_INVERTED: assert property (@(posedge clk) disable iff (rst)
    load |=> (staged_n == ~$past(din))) else $error("staged copy not inverted"); // R3

endmodule

// File: rtl/shadow_cfg_commit.sv
module shadow_cfg_commit
  import shadow_cfg_pkg::*;
#(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] RESVAL = '0,
  parameter access_e           ACCESS = ACC_RW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              commit,
  input  logic [DATA_W-1:0] din,
  output logic [DATA_W-1:0] q,
  output logic              err_storage
);

  logic [DATA_W-1:0] q_r;
  logic [DATA_W-1:0] shadow_n;
  logic [DATA_W-1:0] nxt;
  logic              err_r;

  generate
    if (ACCESS == ACC_W1S) begin : g_set
      assign nxt = q_r | din;
    end else if (ACCESS == ACC_W0C) begin : g_clr
      assign nxt = q_r & din;
    end else begin : g_rep
      assign nxt = din;
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      q_r      <= RESVAL;
      shadow_n <= ~RESVAL;
    end else if (commit) begin
      q_r      <= nxt;
      shadow_n <= ~nxt;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      err_r <= 1'b0;
    end else begin
      err_r <= (shadow_n != ~q_r);
    end
  end

  assign q           = q_r;
  assign err_storage = err_r;

  AST_COMMIT_COHERENT: assert property (@(posedge clk) disable iff (rst)
    commit |=> (shadow_n == ~q_r)) else $error("commit left copies apart"); // R8

  AST_COMMIT_CLEARS_ERR: assert property (@(posedge clk) disable iff (rst)
    commit |=> ##1 !err_storage) else $error("storage error after clean commit"); // R8

endmodule

// File: rtl/shadow_cfg_reg.sv
module shadow_cfg_reg
  import shadow_cfg_pkg::*;
#(
  parameter int unsigned       DATA_W = 8,
  parameter logic [DATA_W-1:0] RESVAL = '0,
  parameter access_e           ACCESS = ACC_RW
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              sw_we,
  input  logic [DATA_W-1:0] sw_wdata,
  input  logic              sw_re,
  input  logic              hw_upd,
  input  logic [DATA_W-1:0] hw_data,
  output logic [DATA_W-1:0] q,
  output logic              err_update,
  output logic              err_storage
);

  localparam bit HW_OWNED = (ACCESS == ACC_RO);

  logic              wr_ev;
  logic [DATA_W-1:0] wr_data;
  logic              second;
  logic              match;
  logic              commit;
  logic              mismatch;
  logic              err_upd_r;

  // Select the update source by access type.
  assign wr_ev   = HW_OWNED ? hw_upd  : sw_we;
  assign wr_data = HW_OWNED ? hw_data : sw_wdata;

  shadow_cfg_phase #(
    .RD_CLEARS (!HW_OWNED)
  ) u_phase (
    .clk    (clk),
    .rst    (rst),
    .wr_ev  (wr_ev),
    .rd_ev  (sw_re),
    .second (second)
  );

  shadow_cfg_stage #(
    .DATA_W (DATA_W),
    .RESVAL (RESVAL)
  ) u_stage (
    .clk   (clk),
    .rst   (rst),
    .load  (wr_ev && !second),
    .din   (wr_data),
    .match (match)
  );

  assign commit   = wr_ev && second && match;
  assign mismatch = wr_ev && second && !match;

  shadow_cfg_commit #(
    .DATA_W (DATA_W),
    .RESVAL (RESVAL),
    .ACCESS (ACCESS)
  ) u_commit (
    .clk         (clk),
    .rst         (rst),
    .commit      (commit),
    .din         (wr_data),
    .q           (q),
    .err_storage (err_storage)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      err_upd_r <= 1'b0;
    end else begin
      err_upd_r <= mismatch;
    end
  end

  assign err_update = err_upd_r;

  AST_FIRST_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_ev && !second) |=> $stable(q)) else $error("first write changed q"); // R2

  AST_MISMATCH_FLAG: assert property (@(posedge clk) disable iff (rst)
    mismatch |=> (err_update && $stable(q) && !second)) else $error("mismatch handling"); // R4

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    !wr_ev |=> $stable(q)) else $error("q moved without update"); // R7

  AST_ERR_CAUSE: assert property (@(posedge clk) disable iff (rst)
    err_update |-> $past(wr_ev && second)) else $error("spurious update error"); // R4

endmodule

// File: tb/shadow_cfg_reg_tb_top.sv
module shadow_cfg_reg_tb_top;
  import shadow_cfg_pkg::*;

  localparam int unsigned W   = 4;
  localparam logic [W-1:0] RV = 4'h5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic sw_we = 1'b0, sw_re = 1'b0, hw_upd = 1'b0;
  logic [W-1:0] sw_wdata = '0, hw_data = '0;

  logic [W-1:0] q_o [4];
  logic         eu_o [4];
  logic         es_o [4];

  always #10 clk = ~clk;  // 50 MHz

  shadow_cfg_reg #(.DATA_W(W), .RESVAL(RV), .ACCESS(ACC_RW)) dut_i (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_re(sw_re),
    .hw_upd(hw_upd), .hw_data(hw_data), .q(q_o[0]), .err_update(eu_o[0]), .err_storage(es_o[0]));
  shadow_cfg_reg #(.DATA_W(W), .RESVAL(RV), .ACCESS(ACC_RO)) dut_ro (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_re(sw_re),
    .hw_upd(hw_upd), .hw_data(hw_data), .q(q_o[1]), .err_update(eu_o[1]), .err_storage(es_o[1]));
  shadow_cfg_reg #(.DATA_W(W), .RESVAL(RV), .ACCESS(ACC_W1S)) dut_w1s (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_re(sw_re),
    .hw_upd(hw_upd), .hw_data(hw_data), .q(q_o[2]), .err_update(eu_o[2]), .err_storage(es_o[2]));
  shadow_cfg_reg #(.DATA_W(W), .RESVAL(RV), .ACCESS(ACC_W0C)) dut_w0c (
    .clk(clk), .rst(rst), .sw_we(sw_we), .sw_wdata(sw_wdata), .sw_re(sw_re),
    .hw_upd(hw_upd), .hw_data(hw_data), .q(q_o[3]), .err_update(eu_o[3]), .err_storage(es_o[3]));

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  // Bench model per instance: 0 replace, 1 hardware-owned, 2 set, 3 clear.
  logic [W-1:0] mq  [4];
  logic [W-1:0] mst [4];
  bit           mph [4];
  bit           meu [4];
  bit           mism[4];
  bit           mes [4];

  task automatic chk(input string tag, input int i, input string what,
                     input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s dut%0d %s actual=%h expected=%h", tag, i, what, act, exp);
    end
  endtask

  task automatic cyc(input bit we, input logic [W-1:0] wd, input bit re,
                     input bit upd, input logic [W-1:0] hd, input string tag);
    @(negedge clk);
    sw_we = we; sw_wdata = wd; sw_re = re; hw_upd = upd; hw_data = hd;
    @(posedge clk);
    for (int i = 0; i < 4; i++) begin
      bit           wr;
      logic [W-1:0] d;
      wr     = (i == 1) ? upd : we;
      d      = (i == 1) ? hd : wd;
      mes[i] = mism[i];
      meu[i] = 1'b0;
      if (wr) begin
        if (!mph[i]) begin
          mst[i] = d;
          mph[i] = 1'b1;
        end else begin
          if (d == mst[i]) begin
            case (i)
              2:       mq[i] = mq[i] | d;
              3:       mq[i] = mq[i] & d;
              default: mq[i] = d;
            endcase
            mism[i] = 1'b0;
          end else begin
            meu[i] = 1'b1;
          end
          mph[i] = 1'b0;
        end
      end else if (re && i != 1) begin
        mph[i] = 1'b0;
      end
    end
    #5;
    for (int i = 0; i < 4; i++) begin
      chk(tag, i, "q", q_o[i], mq[i]);
      chk(tag, i, "err_update", {3'b0, eu_o[i]}, {3'b0, meu[i]});
      chk(tag, i, "err_storage", {3'b0, es_o[i]}, {3'b0, mes[i]});
    end
  endtask

  initial begin
    for (int i = 0; i < 4; i++) begin
      mq[i] = RV; mst[i] = RV; mph[i] = 1'b0; meu[i] = 1'b0; mism[i] = 1'b0; mes[i] = 1'b0;
    end
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst = 1'b0;
    #5;
    // R1: reset state
    for (int i = 0; i < 4; i++) begin
      chk("R1", i, "q", q_o[i], RV);
      chk("R1", i, "err_update", {3'b0, eu_o[i]}, 4'h0);
      chk("R1", i, "err_storage", {3'b0, es_o[i]}, 4'h0);
    end

    // Exhaustive pairs of first and confirm values, on both update ports.
    for (int a = 0; a < 16; a++) begin
      for (int b = 0; b < 16; b++) begin
        cyc(1'b1, W'(a), 1'b0, 1'b1, W'(a), "R2");
        cyc(1'b1, W'(b), 1'b0, 1'b1, W'(b), "R3 R4 R5");
      end
    end

    // R6: read between the two writes abandons the update (software modes).
    cyc(1'b1, 4'h3, 1'b0, 1'b0, 4'h0, "R2");
    cyc(1'b0, 4'h0, 1'b1, 1'b0, 4'h0, "R6");
    cyc(1'b1, 4'h9, 1'b0, 1'b0, 4'h0, "R6");
    cyc(1'b1, 4'h9, 1'b0, 1'b0, 4'h0, "R6 R3");
    // R6: write wins over a read in the same cycle.
    cyc(1'b1, 4'hA, 1'b0, 1'b0, 4'h0, "R6");
    cyc(1'b1, 4'hA, 1'b1, 1'b0, 4'h0, "R6");

    // R7: hardware-owned mode ignores software writes, keeps phase over reads.
    cyc(1'b0, 4'h0, 1'b0, 1'b1, 4'h6, "R7");
    cyc(1'b0, 4'h0, 1'b1, 1'b0, 4'h0, "R7");
    cyc(1'b1, 4'hF, 1'b0, 1'b0, 4'h0, "R7");
    cyc(1'b1, 4'hF, 1'b0, 1'b0, 4'h0, "R7");
    cyc(1'b0, 4'h0, 1'b0, 1'b1, 4'h6, "R7 R3");
    // R9: software modes ignore the hardware port.
    cyc(1'b0, 4'h0, 1'b0, 1'b1, 4'hC, "R9");
    cyc(1'b0, 4'h0, 1'b0, 1'b1, 4'hC, "R9");

    // R8: corrupt the shadow copy of the replace instance.
    @(negedge clk);
    force dut_i.u_commit.shadow_n = ~mq[0] ^ 4'h1;
    mism[0] = 1'b1;
    cyc(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, "R8");
    release dut_i.u_commit.shadow_n;
    cyc(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, "R8");
    cyc(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, "R8");
    cyc(1'b1, 4'h7, 1'b0, 1'b0, 4'h0, "R8");
    cyc(1'b1, 4'h7, 1'b0, 1'b0, 4'h0, "R8");
    cyc(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, "R8");
    cyc(1'b0, 4'h0, 1'b0, 1'b0, 4'h0, "R8");

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule